// File: doc/BRIEF.md
# SPMI Command Register Frontend

This block is the software-facing half of a power-management serial bus master. It sits on an APB bus as a zero-wait-state slave and turns register writes into single transactions for a backend engine. Software first loads up to four 32-bit payload words. It then writes one command word that carries a launch bit, an opcode, a byte count, a target slave ID and a 16-bit register address. The block latches the command and its payload and raises a request to the backend. It holds that request until the backend acknowledges.

When the backend acknowledges, the block stores the returned read bytes and a done/fail result in a bank owned by the slave ID of that transaction. Software polls this status and reads the data words of that slave. Payload bytes travel big-endian inside each 32-bit word. Each instance decodes the register set of one channel. Channel banks repeat every 0x300 bytes, and the `CHANNEL` parameter picks which bank an instance answers.

Top module: `spmi_cmd_frontend`

## Requirements
- R1: The bank base is `CHANNEL`*0x300. Relative to that base, the command word is at 0x100 and payload word k (k=0..3) is at 0x104+4k. The status of slave s (s=0..15) is at 0x200+0x20*s, and read word k of slave s is at 0x204+0x20*s+4k. Payload words read back what was last written to them. `pready_o` is always high.
- R2: An access raises `pslverr_o` during its access phase, returns zero read data and changes no state in these cases: it lies outside the bank, its address is not a multiple of 4, it hits no listed offset, or it is a write to a status or read-data offset.
- R3: Command word layout: bit 31 launch, bits 27:24 opcode (0 zero-write, 1 write, 2 read, 3 extended write, 4 extended read, 5 extended-long write, 6 extended-long read, 7 reset, 8 sleep, 9 shutdown, 10 wakeup), bits 23:20 byte count minus one, bits 19:16 slave ID, bits 15:0 register address. A command write with bit 31 set while idle drives `req_o` high from the next cycle, with the opcode, count-minus-one, slave ID and address on the request ports.
- R4: While `req_o` is high and `ack_i` is low, `req_o` and every request field stay unchanged in the next cycle.
- R5: The payload is captured when the command is accepted. Payload word k drives `req_wdata_o[32k+31:32k]`. Byte j of the transfer sits in word j/4 at bits 31-8*(j%4) down to 24-8*(j%4). Bytes with index above count-minus-one are driven as zero. Later writes to the payload registers do not change a request already in flight.
- R6: An accepted command clears done (status bit 0) and fail (status bit 2) of its own slave and leaves the status of every other slave unchanged.
- R7: `ack_i` while a request is pending completes it. In the next cycle `req_o` is low, and the slave of that transaction has done set and fail equal to `ack_err_i`. Its four read words hold `ack_rdata_i`, using the same word and byte layout as R5.
- R8: Read bytes with index above the count-minus-one of the completing transaction are stored as zero.
- R9: A command write with bit 31 clear, or one that arrives while a request is pending, is ignored: no request field, payload or status changes.
- R10: Reading the command word returns the fields of the last accepted command, with bit 31 showing whether a request is pending.
- R11: `ack_i` while no request is pending has no effect on any status or read data.
- R12: Reset (`rst_ni` low) clears the payload words, the command fields, the pending request, and all status and read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | AW | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error |
| req_o | output | 1 | Backend request pending |
| req_opcode_o | output | 4 | Request opcode |
| req_len_o | output | 4 | Request byte count minus one |
| req_sid_o | output | 4 | Request slave ID |
| req_addr_o | output | 16 | Request register address |
| req_wdata_o | output | 128 | Request payload, word k in bits 32k+31:32k |
| ack_i | input | 1 | Backend acknowledge |
| ack_err_i | input | 1 | Backend failure flag, valid with ack_i |
| ack_rdata_i | input | 128 | Backend read bytes, same layout as req_wdata_o |

## Verification
The bench builds the block with `CHANNEL` = 1, so the bank starts at 0x300. This makes it possible to check that addresses of channel 0 fall outside the bank and raise an error, and that the upper slave banks (up to 0x6F0) decode cleanly above the next channel's base. The other parameters keep their defaults, so all 16 slave banks and the full 16-byte payload are used. The tests cover one-byte, three-byte and sixteen-byte counts, commands to a busy engine, acknowledges while idle, and a reset during a pending request.

// File: rtl/spmi_fe_pkg.sv
package spmi_fe_pkg;
  localparam int DW          = 32;
  localparam int SID_W       = 4;
  localparam int NUM_SLAVES  = 1 << SID_W;
  localparam int OPC_W       = 4;
  localparam int LEN_W       = 4;
  localparam int RADDR_W     = 16;
  localparam int NUM_WORDS   = 4;
  localparam int WORD_IDX_W  = $clog2(NUM_WORDS);
  localparam int BYTES_PER_W = DW / 8;
  localparam int NUM_BYTES   = NUM_WORDS * BYTES_PER_W;
  localparam int PAY_W       = NUM_WORDS * DW;

  localparam int CH_STRIDE   = 'h300;
  localparam int BANK_SPAN   = 'h400;
  localparam int OFS_CMD     = 'h100;
  localparam int OFS_WDATA   = 'h104;
  localparam int OFS_STAT    = 'h200;
  localparam int SLOT_SH     = 5;
  localparam int LAUNCH_BIT  = 31;
  localparam int ST_DONE_BIT = 0;
  localparam int ST_FAIL_BIT = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_ZERO_WR = 4'd0, OP_WR     = 4'd1, OP_RD       = 4'd2,
    OP_EXT_WR  = 4'd3, OP_EXT_RD = 4'd4, OP_EXTL_WR  = 4'd5,
    OP_EXTL_RD = 4'd6, OP_RESET  = 4'd7, OP_SLEEP    = 4'd8,
    OP_SHUTDN  = 4'd9, OP_WAKEUP = 4'd10
  } opcode_e;

  typedef struct packed {
    logic [OPC_W-1:0]   opc;
    logic [LEN_W-1:0]   len_m1;
    logic [SID_W-1:0]   sid;
    logic [RADDR_W-1:0] addr;
  } cmd_t;

  typedef enum logic [2:0] {SEL_NONE, SEL_CMD, SEL_WDATA, SEL_STAT, SEL_RDATA} sel_e;

  typedef struct packed {
    sel_e                  kind;
    logic [WORD_IDX_W-1:0] word;
    logic [SID_W-1:0]      sid;
  } dec_t;

  // keep bytes 0..len_m1, big-endian within each word
  function automatic logic [PAY_W-1:0] lane_mask(input logic [LEN_W-1:0] len_m1);
    logic [PAY_W-1:0] m;
    m = '0;
    for (int j = 0; j < NUM_BYTES; j++) begin
      if (j <= int'(len_m1))
        m[DW*(j/BYTES_PER_W) + (DW-8) - 8*(j%BYTES_PER_W) +: 8] = 8'hff;
    end
    return m;
  endfunction
endpackage

// File: rtl/spmi_fe_decode.sv
module spmi_fe_decode
  import spmi_fe_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CHANNEL = 0
) (
  input  logic [AW-1:0] paddr_i,
  output dec_t          dec_o
);
  localparam logic [AW-1:0] BASE = AW'(CHANNEL * CH_STRIDE);
  localparam logic [AW-1:0] SPAN = AW'(BANK_SPAN);

  logic [AW-1:0]      ofs;
  logic               hit;
  logic [SLOT_SH-1:0] slot;
  logic [SLOT_SH-1:0] rword;
  logic [AW-1:0]      wword;

  always_comb begin
    ofs   = paddr_i - BASE;
    hit   = (paddr_i >= BASE) && (ofs < SPAN) && (ofs[1:0] == 2'b00);
    slot  = ofs[SLOT_SH-1:0];
    rword = (slot - SLOT_SH'(BYTES_PER_W)) >> 2;
    wword = (ofs - AW'(OFS_WDATA)) >> 2;
    dec_o = '{kind: SEL_NONE, word: '0, sid: '0};
    if (hit) begin
      if (ofs == AW'(OFS_CMD)) begin
        dec_o.kind = SEL_CMD;
      end else if (ofs >= AW'(OFS_WDATA) && ofs < AW'(OFS_WDATA + BYTES_PER_W*NUM_WORDS)) begin
        dec_o.kind = SEL_WDATA;
        dec_o.word = wword[WORD_IDX_W-1:0];
      end else if (ofs >= AW'(OFS_STAT)) begin
        dec_o.sid = ofs[SLOT_SH +: SID_W];
        if (slot == '0) begin
          dec_o.kind = SEL_STAT;
        end else if (slot <= SLOT_SH'(BYTES_PER_W*NUM_WORDS)) begin
          dec_o.kind = SEL_RDATA;
          dec_o.word = rword[WORD_IDX_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/spmi_fe_launch.sv
module spmi_fe_launch
  import spmi_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  cmd_t             cmd_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic             ack_i,
  output logic             busy_o,
  output cmd_t             cmd_o,
  output logic [PAY_W-1:0] pay_o,
  output logic             launch_o,
  output logic             finish_o
);
  logic             busy_q;
  cmd_t             cmd_q;
  logic [PAY_W-1:0] pay_q;

  assign launch_o = cmd_wr_i && !busy_q;
  assign finish_o = busy_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      pay_q  <= '0;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      cmd_q  <= cmd_i;
      pay_q  <= pay_i & lane_mask(cmd_i.len_m1);
    end else if (finish_o) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign cmd_o  = cmd_q;
  assign pay_o  = pay_q;

  // R4 R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> (busy_q && $stable(cmd_q) && $stable(pay_q)));

  // R7
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i) |=> !busy_q);
endmodule

// File: rtl/spmi_fe_slot.sv
module spmi_fe_slot
  import spmi_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             err_i,
  input  logic [PAY_W-1:0] rdata_i,
  output logic             done_o,
  output logic             fail_o,
  output logic [PAY_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
      rdata_o <= '0;
    end else if (clr_i) begin
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
    end else if (upd_i) begin
      done_o  <= 1'b1;
      fail_o  <= err_i;
      rdata_o <= rdata_i;
    end
  end

  // R6
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && upd_i));
endmodule

// File: rtl/spmi_cmd_frontend.sv
module spmi_cmd_frontend
  import spmi_fe_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CHANNEL = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [AW-1:0]      paddr_i,
  input  logic [DW-1:0]      pwdata_i,
  output logic [DW-1:0]      prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  output logic               req_o,
  output logic [OPC_W-1:0]   req_opcode_o,
  output logic [LEN_W-1:0]   req_len_o,
  output logic [SID_W-1:0]   req_sid_o,
  output logic [RADDR_W-1:0] req_addr_o,
  output logic [PAY_W-1:0]   req_wdata_o,
  input  logic               ack_i,
  input  logic               ack_err_i,
  input  logic [PAY_W-1:0]   ack_rdata_i
);
  dec_t             dec;
  logic             access, wr, err, cmd_wr, launch, finish, busy;
  cmd_t             cmd_in, cmd_q;
  logic [DW-1:0]    wdata_q [NUM_WORDS];
  logic [PAY_W-1:0] pay_flat, pay_q, rd_masked;
  logic [NUM_SLAVES-1:0] done_v, fail_v;
  logic [PAY_W-1:0] rd_v [NUM_SLAVES];

  spmi_fe_decode #(.AW(AW), .CHANNEL(CHANNEL)) i_decode (
    .paddr_i (paddr_i),
    .dec_o   (dec)
  );

  assign access = psel_i && penable_i;
  assign wr     = access && pwrite_i;
  assign err    = access && ((dec.kind == SEL_NONE) ||
                  (pwrite_i && (dec.kind == SEL_STAT || dec.kind == SEL_RDATA)));
  assign cmd_wr = wr && (dec.kind == SEL_CMD) && pwdata_i[LAUNCH_BIT];
  assign cmd_in = cmd_t'(pwdata_i[$bits(cmd_t)-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_WORDS; k++) wdata_q[k] <= '0;
    end else if (wr && dec.kind == SEL_WDATA) begin
      wdata_q[dec.word] <= pwdata_i;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_WORDS; k++) pay_flat[DW*k +: DW] = wdata_q[k];
  end

  spmi_fe_launch i_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_wr_i (cmd_wr),
    .cmd_i    (cmd_in),
    .pay_i    (pay_flat),
    .ack_i    (ack_i),
    .busy_o   (busy),
    .cmd_o    (cmd_q),
    .pay_o    (pay_q),
    .launch_o (launch),
    .finish_o (finish)
  );

  assign rd_masked = ack_rdata_i & lane_mask(cmd_q.len_m1);

  for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_slot
    spmi_fe_slot i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (launch && cmd_in.sid == SID_W'(g)),
      .upd_i   (finish && cmd_q.sid == SID_W'(g)),
      .err_i   (ack_err_i),
      .rdata_i (rd_masked),
      .done_o  (done_v[g]),
      .fail_o  (fail_v[g]),
      .rdata_o (rd_v[g])
    );
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !err) begin
      unique case (dec.kind)
        SEL_CMD:   prdata_o = {busy, {(DW-1-$bits(cmd_t)){1'b0}}, cmd_q};
        SEL_WDATA: prdata_o = wdata_q[dec.word];
        SEL_STAT: begin
          prdata_o[ST_DONE_BIT] = done_v[dec.sid];
          prdata_o[ST_FAIL_BIT] = fail_v[dec.sid];
        end
        SEL_RDATA: prdata_o = rd_v[dec.sid][DW*dec.word +: DW];
        default:   prdata_o = '0;
      endcase
    end
  end

  assign pready_o     = 1'b1;
  assign pslverr_o    = err;
  assign req_o        = busy;
  assign req_opcode_o = cmd_q.opc;
  assign req_len_o    = cmd_q.len_m1;
  assign req_sid_o    = cmd_q.sid;
  assign req_addr_o   = cmd_q.addr;
  assign req_wdata_o  = pay_q;

  // R6
  launch_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (!done_v[req_sid_o] && !fail_v[req_sid_o]));

  // R7
  finish_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (done_v[$past(req_sid_o)] && (fail_v[$past(req_sid_o)] == $past(ack_err_i))));

  // R2
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pslverr_o) |-> (prdata_o == '0));

  // R11
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !(psel_i && penable_i && pwrite_i)) |=> ($stable(done_v) && $stable(fail_v)));
endmodule

// File: tb/test_spmi_cmd_frontend.sv
module test_spmi_cmd_frontend;
  localparam int AW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic req;
  logic [3:0] req_opc, req_len, req_sid;
  logic [15:0] req_addr;
  logic [127:0] req_wdata;
  logic ack = 0, ack_err = 0;
  logic [127:0] ack_rdata = '0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spmi_cmd_frontend #(.AW(AW), .CHANNEL(1)) i_spmi_cmd_frontend (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .req_o(req), .req_opcode_o(req_opc), .req_len_o(req_len), .req_sid_o(req_sid),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata), .ack_i(ack), .ack_err_i(ack_err),
    .ack_rdata_i(ack_rdata));

  // behavioural model
  logic [31:0] m_wd [4];
  logic [31:0] m_pay [4];
  logic [31:0] m_rd [16][4];
  logic m_done [16];
  logic m_fail [16];
  logic m_busy;
  logic [3:0] m_opc, m_len, m_sid;
  logic [15:0] m_addr;

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // kind: 0 none, 1 cmd, 2 payload word, 3 status, 4 read word
  function automatic void mdecode(input int a, output int kind, output int idx, output int sid);
    int o, w;
    kind = 0; idx = 0; sid = 0;
    if (a < 'h300 || a % 4 != 0) return;
    o = a - 'h300;
    if (o >= 'h400) return;
    if (o == 'h100) kind = 1;
    else if (o >= 'h104 && o <= 'h110) begin kind = 2; idx = (o - 'h104) / 4; end
    else if (o >= 'h200) begin
      sid = (o - 'h200) / 32;
      w = (o - 'h200) % 32;
      if (w == 0) kind = 3;
      else if (w <= 16) begin kind = 4; idx = (w - 4) / 4; end
    end
  endfunction

  function automatic logic [31:0] mask_word(input logic [31:0] v, input int k, input int len);
    logic [31:0] r = v;
    for (int b = 0; b < 4; b++)
      if (4*k + b > len) r[31-8*b -: 8] = 8'h00;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_opc = 0; m_len = 0; m_sid = 0; m_addr = 0;
      for (int k = 0; k < 4; k++) begin m_wd[k] = 0; m_pay[k] = 0; end
      for (int s = 0; s < 16; s++) begin
        m_done[s] = 0; m_fail[s] = 0;
        for (int k = 0; k < 4; k++) m_rd[s][k] = 0;
      end
    end else begin
      automatic logic ob = m_busy;
      automatic int kind, idx, sid;
      if (ob && ack) begin
        m_busy = 0;
        m_done[m_sid] = 1;
        m_fail[m_sid] = ack_err;
        for (int k = 0; k < 4; k++) m_rd[m_sid][k] = mask_word(ack_rdata[32*k +: 32], k, m_len);
      end
      if (psel && penable && pwrite) begin
        mdecode(int'(paddr), kind, idx, sid);
        if (kind == 2) m_wd[idx] = pwdata;
        if (kind == 1 && pwdata[31] && !ob) begin
          m_busy = 1;
          m_opc = pwdata[27:24]; m_len = pwdata[23:20]; m_sid = pwdata[19:16]; m_addr = pwdata[15:0];
          m_done[m_sid] = 0; m_fail[m_sid] = 0;
          for (int k = 0; k < 4; k++) m_pay[k] = mask_word(m_wd[k], k, m_len);
        end
      end
    end
  end

  // per-clock comparison of the request side
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 req_o", 128'(req), 128'(m_busy));
      if (m_busy) begin
        chk("R4 fields", 128'({req_opc, req_len, req_sid, req_addr}), 128'({m_opc, m_len, m_sid, m_addr}));
        chk("R5 payload", req_wdata, {m_pay[3], m_pay[2], m_pay[1], m_pay[0]});
      end
    end
  end

  function automatic logic [31:0] model_read(input int a, output logic e);
    int kind, idx, sid;
    mdecode(a, kind, idx, sid);
    e = (kind == 0);
    case (kind)
      1: return {m_busy, 3'b0, m_opc, m_len, m_sid, m_addr};
      2: return m_wd[idx];
      3: return {29'b0, m_fail[sid], 1'b0, m_done[sid]};
      4: return m_rd[sid][idx];
      default: return 32'h0;
    endcase
  endfunction

  task automatic apb_write(input int a, input logic [31:0] d, input string rq);
    int kind, idx, sid;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = AW'(a); pwdata = d;
    @(negedge clk);
    penable = 1;
    #2;
    mdecode(a, kind, idx, sid);
    chk({rq, " pslverr"}, 128'(pslverr), 128'(kind == 0 || kind == 3 || kind == 4));
    chk("R1 pready", 128'(pready), 128'(1));
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input int a, input string rq, output logic [31:0] d);
    logic e;
    logic [31:0] x;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = AW'(a);
    @(negedge clk);
    penable = 1;
    #2;
    x = model_read(a, e);
    if (e) x = 0;
    d = prdata;
    chk({rq, " prdata"}, 128'(prdata), 128'(x));
    chk({rq, " pslverr"}, 128'(pslverr), 128'(e));
    chk("R1 pready", 128'(pready), 128'(1));
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic backend_ack(input logic e, input logic [127:0] d);
    @(negedge clk);
    ack = 1; ack_err = e; ack_rdata = d;
    @(negedge clk);
    ack = 0; ack_err = 0; ack_rdata = '0;
  endtask

  function automatic int st(input int s); return 'h500 + 32*s; endfunction
  function automatic int rdw(input int s, input int k); return 'h504 + 32*s + 4*k; endfunction

  task automatic summary;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  localparam int CMD = 'h400;
  localparam logic [127:0] RPAT = {32'hD1D2D3D4, 32'hC1C2C3C4, 32'hB1B2B3B4, 32'hA1A2A3A4};

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 req", 128'(req), 128'(0));
    apb_read(CMD, "R12 cmd", d);           chk("R12 cmd value", 128'(d), 128'(0));
    apb_read(st(5), "R12 status", d);      chk("R12 status value", 128'(d), 128'(0));
    apb_read('h404, "R12 payload", d);     chk("R12 payload value", 128'(d), 128'(0));

    // R1 payload words and readback
    apb_write('h404, 32'h11223344, "R1");
    apb_write('h408, 32'h55667788, "R1");
    apb_write('h40C, 32'h99AABBCC, "R1");
    apb_write('h410, 32'hDDEEFF00, "R1");
    apb_read('h40C, "R1 word2", d);        chk("R1 word2 value", 128'(d), 128'(32'h99AABBCC));

    // R3 R5: 3-byte write to slave 5
    apb_write(CMD, 32'h81251234, "R3");
    chk("R3 req rose", 128'(req), 128'(1));
    chk("R3 fields", 128'({req_opc, req_len, req_sid, req_addr}), 128'({4'd1, 4'd2, 4'd5, 16'h1234}));
    chk("R5 lane mask", req_wdata, 128'h00000000_00000000_00000000_11223300);
    apb_read(CMD, "R10 busy", d);          chk("R10 busy value", 128'(d), 128'(32'h81251234));

    // R5 payload write during flight
    apb_write('h404, 32'hCAFEF00D, "R5");
    chk("R5 in flight", req_wdata[31:0], 128'(32'h11223300));
    apb_read('h404, "R1 new word0", d);    chk("R1 new word0 value", 128'(d), 128'(32'hCAFEF00D));

    // R7 R8 completion
    backend_ack(1'b0, RPAT);
    chk("R7 req drop", 128'(req), 128'(0));
    apb_read(st(5), "R7 status", d);       chk("R7 status value", 128'(d), 128'(1));
    apb_read(rdw(5, 0), "R8 word0", d);    chk("R8 word0 value", 128'(d), 128'(32'hA1A2A300));
    apb_read(rdw(5, 1), "R8 word1", d);    chk("R8 word1 value", 128'(d), 128'(0));
    apb_read(CMD, "R10 idle", d);          chk("R10 idle value", 128'(d), 128'(32'h01251234));

    // R11 stray acknowledge
    backend_ack(1'b1, ~RPAT);
    apb_read(st(5), "R11 status", d);      chk("R11 status value", 128'(d), 128'(1));
    apb_read(rdw(5, 0), "R11 rdata", d);   chk("R11 rdata value", 128'(d), 128'(32'hA1A2A300));

    // R9 launch bit clear
    apb_write(CMD, 32'h02F37777, "R9");
    chk("R9 no launch", 128'(req), 128'(0));
    apb_read(CMD, "R9 cmd kept", d);       chk("R9 cmd kept value", 128'(d), 128'(32'h01251234));

    // 16-byte read to slave 9, busy command to slave 5 ignored
    apb_write(CMD, 32'h82F9BEEF, "R3");
    chk("R5 full payload", req_wdata, {32'hDDEEFF00, 32'h99AABBCC, 32'h55667788, 32'hCAFEF00D});
    apb_write(CMD, 32'h81051111, "R9");
    chk("R9 sid kept", 128'(req_sid), 128'(9));
    apb_read(st(5), "R9 status kept", d);  chk("R9 status kept value", 128'(d), 128'(1));
    repeat (3) @(negedge clk);
    chk("R4 still pending", 128'(req), 128'(1));
    backend_ack(1'b1, RPAT);
    apb_read(st(9), "R7 fail", d);         chk("R7 fail value", 128'(d), 128'(5));
    for (int k = 0; k < 4; k++) begin
      apb_read(rdw(9, k), "R8 full", d);   chk("R8 full value", 128'(d), 128'(RPAT[32*k +: 32]));
    end

    // R6 clear only the addressed slave
    apb_write(CMD, 32'h8A090001, "R6");
    apb_read(st(9), "R6 cleared", d);      chk("R6 cleared value", 128'(d), 128'(0));
    apb_read(st(5), "R6 other", d);        chk("R6 other value", 128'(d), 128'(1));
    backend_ack(1'b0, '0);
    apb_read(st(9), "R7 done9", d);        chk("R7 done9 value", 128'(d), 128'(1));

    // top slave bank, 1-byte transfer
    apb_write(CMD, 32'h840F00AA, "R3");
    backend_ack(1'b0, RPAT);
    apb_read(rdw(15, 0), "R8 one byte", d); chk("R8 one byte value", 128'(d), 128'(32'hA1000000));
    apb_read(rdw(15, 3), "R1 top word", d); chk("R1 top word value", 128'(d), 128'(0));

    // R2 error paths
    apb_read('h100, "R2 other channel", d);
    apb_read('h406, "R2 unaligned", d);
    apb_read('h514, "R2 gap", d);
    apb_read('h700, "R2 beyond", d);
    apb_read('h414, "R2 after payload", d);
    apb_write(st(5), 32'hFFFFFFFF, "R2 status write");
    apb_write(rdw(5, 0), 32'h12345678, "R2 rdata write");
    apb_write('h300, 32'h81051111, "R2 undecoded");
    chk("R2 no launch", 128'(req), 128'(0));
    apb_read(st(5), "R2 status kept", d);  chk("R2 status kept value", 128'(d), 128'(1));
    apb_read(rdw(5, 0), "R2 rdata kept", d); chk("R2 rdata kept value", 128'(d), 128'(32'hA1A2A300));

    // R12 reset during pending request
    apb_write(CMD, 32'h81030042, "R3");
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R12 req cleared", 128'(req), 128'(0));
    rst_n = 1;
    apb_read(st(5), "R12 status", d);      chk("R12 status cleared", 128'(d), 128'(0));
    apb_read(rdw(9, 0), "R12 rdata", d);   chk("R12 rdata cleared", 128'(d), 128'(0));
    apb_read('h404, "R12 payload", d);     chk("R12 payload cleared", 128'(d), 128'(0));

    repeat (2) @(negedge clk);
    summary();
  end
endmodule